// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Service

This block is a watchdog timer that software has to service inside a time window. Software sets up three things through a small register read/write port: a reload value, the action taken on a fault, and the size of the window. It then arms the block by writing a 32-bit arming word. Arming loads a down-counter with the reload value scaled up by a fixed power of two. From then on the counter counts down by one on every clock.

To service the timer, software writes two key words to the key register, one after the other. The second word is accepted only while the counter is inside the open window, which is the final part of the period. An accepted service reloads the counter. There are two fault cases: the second key word arrives while the window is still closed, or the counter reaches zero with no service. A fault sets a sticky status flag, reloads the counter and triggers the chosen action. That action is either a one-cycle interrupt pulse or a reset request that stays high until system reset. Once armed, the block cannot be disarmed by software.

Top module: `win_wdog`

## Requirements
- R1: After reset the block is disarmed. The counter reads 0, the status flag is 0, and both `nmi_pulse` and `rst_req` are low.
- R2: The block arms only when the control register (offset 0x00) is written with 0xA98559DA. Any other write to it before arming is ignored. Once armed, no write can disarm it. Reading the control register returns the armed state in bit 0.
- R3: Arming loads the counter with the reload field shifted left by SHIFT. The counter (read at offset 0x18) then drops by exactly one per clock until a reload.
- R4: If the counter is 0 in a clock and no service is accepted in that clock, a fault is raised and the counter reloads.
- R5: A key write of 0xE51A followed by a key write of 0xA35C (key register, offset 0x04) is a service. A service arriving while the window is open reloads the counter and raises no fault.
- R6: A service whose second word arrives while the window is closed raises a fault.
- R7: Each of these key writes puts the sequence back to idle without a service: a write other than 0xA35C after 0xE51A, a second 0xE51A, and a lone 0xA35C. Key writes made before arming are ignored.
- R8: The window is open while the counter is below the reload value shifted right by N. The window register (offset 0x0C) selects N: 0x50 gives N=1 (the last half of the period, which is the widest choice), 0x40 gives N=2, and every other code gives N=3. The reset value is 0x50.
- R9: Reaction code 0x0A (reaction register, offset 0x10) turns a fault into a single-cycle `nmi_pulse`. Any other code, including the reset value 0x05, turns a fault into `rst_req`, which stays high until reset.
- R10: A fault sets status bit 1 (status register, offset 0x14). Writing 1 to that bit clears it. Writing 0 to it has no effect.
- R11: Changes to the reload field (offset 0x08, reset value all ones), the window code and the reaction code take effect at the next reload. Writes to the reload field and the window code are ignored while a service sequence is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe, one write per clock |
| reg_addr | input | AW | Byte offset of the register being read or written |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| nmi_pulse | output | 1 | One-cycle pulse on a fault when the interrupt reaction is selected |
| rst_req | output | 1 | Sticky reset request on a fault when the reset reaction is selected |

## Verification
If the key sequencer is left in the wrong state, it shows up at the next 0xA35C write. A spurious pending state turns an early write into a fault, so the status flag and the reaction output change one clock after that write. A lost pending state leaves the counter running down with no reload. A wrong window threshold moves the point where a service flips from fault to accepted. The bench sweeps the service instant over every counter value for three reload values and all three window codes, which exposes an error at that boundary cycle. A counter that steps or reloads wrongly moves the expiry fault earlier or later by that many clocks, and the readable counter shows the offset at once.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;
  // register byte offsets
  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_KEY    = 'h04;
  localparam int OFF_RELOAD = 'h08;
  localparam int OFF_WIN    = 'h0C;
  localparam int OFF_REACT  = 'h10;
  localparam int OFF_STAT   = 'h14;
  localparam int OFF_COUNT  = 'h18;

  localparam logic [31:0] ARM_WORD  = 32'hA98559DA;
  localparam logic [31:0] KEY_FIRST = 32'h0000E51A;
  localparam logic [31:0] KEY_LAST  = 32'h0000A35C;

  localparam logic [7:0] REACT_NMI   = 8'h0A;
  localparam logic [7:0] REACT_RESET = 8'h05;
  localparam logic [7:0] WIN_HALF    = 8'h50;
  localparam logic [7:0] WIN_QUARTER = 8'h40;

  typedef enum logic {KS_IDLE, KS_PEND} key_state_e;
endpackage

// File: rtl/win_wdog_keyseq.sv
module win_wdog_keyseq
  import win_wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  output logic        pend,
  output logic        svc_req
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!en) begin
      st_d = KS_IDLE;
    end else if (key_wr) begin
      // any word after the first one ends the sequence
      if (st_q == KS_IDLE && key_data == KEY_FIRST) st_d = KS_PEND;
      else                                           st_d = KS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign pend    = (st_q == KS_PEND);
  assign svc_req = en && key_wr && pend && (key_data == KEY_LAST);
endmodule

// File: rtl/win_wdog_core.sv
module win_wdog_core
  import win_wdog_pkg::*;
#(
  parameter int PW    = 12,
  parameter int SHIFT = 13,
  localparam int CW   = PW + SHIFT
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          start,
  input  logic          svc_req,
  input  logic [PW-1:0] pre_live,
  input  logic [7:0]    win_live,
  input  logic [7:0]    rx_live,
  output logic [CW-1:0] cnt,
  output logic          viol,
  output logic          nmi_sel
);
  logic [CW-1:0] cnt_q, cnt_d, base, thr;
  logic [PW-1:0] pre_sh_q;
  logic [7:0]    win_sh_q, rx_sh_q;
  logic          open, svc_ok, expire, reload;

  always_comb begin
    base = CW'(pre_sh_q) << SHIFT;
    case (win_sh_q)
      WIN_HALF:    thr = base >> 1;
      WIN_QUARTER: thr = base >> 2;
      default:     thr = base >> 3;
    endcase
    open   = (cnt_q < thr);
    svc_ok = svc_req && open;
    expire = en && (cnt_q == '0) && !svc_ok;
    viol   = (svc_req && !open) || expire;
    reload = start || svc_ok || viol;
    if (reload)  cnt_d = CW'(pre_live) << SHIFT;
    else if (en) cnt_d = cnt_q - 1'b1;
    else         cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      pre_sh_q <= '1;
      win_sh_q <= WIN_HALF;
      rx_sh_q  <= REACT_RESET;
    end else begin
      cnt_q <= cnt_d;
      if (reload) begin
        pre_sh_q <= pre_live;
        win_sh_q <= win_live;
        rx_sh_q  <= rx_live;
      end
    end
  end

  assign cnt     = cnt_q;
  assign nmi_sel = (rx_sh_q == REACT_NMI);
endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import win_wdog_pkg::*;
#(
  parameter int PW    = 12,
  parameter int SHIFT = 13,
  parameter int AW    = 8,
  parameter int SYNC  = 2
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          nmi_pulse,
  output logic          rst_req
);
  localparam int CW = PW + SHIFT;

  // reset: asserted at once, released through SYNC flops
  logic [SYNC-1:0] rs_q;
  logic            rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC-2:0], 1'b1};
  end
  assign rst_q = rs_q[SYNC-1];

  logic wr_ctrl, wr_key, wr_pre, wr_win, wr_rx, wr_stat;
  assign wr_ctrl = reg_wr && (reg_addr == AW'(OFF_CTRL));
  assign wr_key  = reg_wr && (reg_addr == AW'(OFF_KEY));
  assign wr_pre  = reg_wr && (reg_addr == AW'(OFF_RELOAD));
  assign wr_win  = reg_wr && (reg_addr == AW'(OFF_WIN));
  assign wr_rx   = reg_wr && (reg_addr == AW'(OFF_REACT));
  assign wr_stat = reg_wr && (reg_addr == AW'(OFF_STAT));

  logic          en_q, en_d, start;
  logic [PW-1:0] pre_q, pre_d;
  logic [7:0]    win_q, win_d, rx_q, rx_d;
  logic          flag_q, flag_d, nmi_q, nmi_d, rrq_q, rrq_d;
  logic          pend, svc_req, viol, nmi_sel;
  logic [CW-1:0] cnt;

  win_wdog_keyseq u_keyseq (
    .clk      (clk),
    .rst_n    (rst_q),
    .en       (en_q),
    .key_wr   (wr_key),
    .key_data (reg_wdata),
    .pend     (pend),
    .svc_req  (svc_req)
  );

  win_wdog_core #(.PW(PW), .SHIFT(SHIFT)) u_core (
    .clk      (clk),
    .rst_n    (rst_q),
    .en       (en_q),
    .start    (start),
    .svc_req  (svc_req),
    .pre_live (pre_q),
    .win_live (win_q),
    .rx_live  (rx_q),
    .cnt      (cnt),
    .viol     (viol),
    .nmi_sel  (nmi_sel)
  );

  always_comb begin
    start  = wr_ctrl && (reg_wdata == ARM_WORD) && !en_q;
    en_d   = en_q || start;
    pre_d  = (wr_pre && !pend) ? reg_wdata[PW-1:0] : pre_q;
    win_d  = (wr_win && !pend) ? reg_wdata[7:0]    : win_q;
    rx_d   = wr_rx ? reg_wdata[7:0] : rx_q;
    flag_d = viol || (flag_q && !(wr_stat && reg_wdata[1]));
    nmi_d  = viol && nmi_sel;
    rrq_d  = rrq_q || (viol && !nmi_sel);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      en_q   <= 1'b0;
      pre_q  <= '1;
      win_q  <= WIN_HALF;
      rx_q   <= REACT_RESET;
      flag_q <= 1'b0;
      nmi_q  <= 1'b0;
      rrq_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      pre_q  <= pre_d;
      win_q  <= win_d;
      rx_q   <= rx_d;
      flag_q <= flag_d;
      nmi_q  <= nmi_d;
      rrq_q  <= rrq_d;
    end
  end

  always_comb begin
    case (reg_addr)
      AW'(OFF_CTRL):   reg_rdata = {31'b0, en_q};
      AW'(OFF_RELOAD): reg_rdata = 32'(pre_q);
      AW'(OFF_WIN):    reg_rdata = {24'b0, win_q};
      AW'(OFF_REACT):  reg_rdata = {24'b0, rx_q};
      AW'(OFF_STAT):   reg_rdata = {30'b0, flag_q, 1'b0};
      AW'(OFF_COUNT):  reg_rdata = 32'(cnt);
      default:         reg_rdata = 32'b0;
    endcase
  end

  assign nmi_pulse = nmi_q;
  assign rst_req   = rrq_q;
endmodule

// File: rtl/win_wdog_chk.sv
module win_wdog_chk #(
  parameter int CW = 25,
  parameter int PW = 12
)(
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          svc_req,
  input logic          viol,
  input logic          pend,
  input logic          nmi,
  input logic          rrq,
  input logic          flag,
  input logic [CW-1:0] cnt,
  input logic [PW-1:0] pre
);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (cnt == '0 && !nmi && !rrq));
  assert_arm_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !svc_req && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  assert_expiry_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !svc_req && cnt == '0) |-> viol);
  assert_nmi_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> !nmi);
  assert_nmi_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> $past(viol));
  assert_rst_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rrq |=> rrq);
  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> flag);
  assert_pend_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> $stable(pre));
endmodule

bind win_wdog win_wdog_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_q),
  .en      (en_q),
  .svc_req (svc_req),
  .viol    (viol),
  .pend    (pend),
  .nmi     (nmi_pulse),
  .rrq     (rst_req),
  .flag    (flag_q),
  .cnt     (cnt),
  .pre     (pre_q)
);

// File: tb/win_wdog_bench.sv
module win_wdog_bench;
  localparam int PW = 4;
  localparam int SH = 2;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [AW-1:0] reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          nmi_pulse, rst_req;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  win_wdog #(.PW(PW), .SHIFT(SH), .AW(AW)) u_win_wdog (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nmi_pulse(nmi_pulse), .rst_req(rst_req)
  );

  localparam logic [7:0] A_CTRL = 8'h00, A_KEY = 8'h04, A_PRE = 8'h08,
                         A_WIN = 8'h0C, A_RX = 8'h10, A_STAT = 8'h14, A_CNT = 8'h18;
  localparam logic [31:0] ARM = 32'hA98559DA, K0 = 32'hE51A, K1 = 32'hA35C;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int r;

    // R1 reset state
    do_reset();
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_CNT, d);  check("R1 count", d, 0);
    rd(A_STAT, d); check("R1 status", d, 0);
    check("R1 nmi", 32'(nmi_pulse), 0);
    check("R1 rst_req", 32'(rst_req), 0);
    rd(A_WIN, d);  check("R8 window reset", d, 32'h50);
    rd(A_RX, d);   check("R9 reaction reset", d, 32'h05);
    rd(A_PRE, d);  check("R11 reload reset", d, 32'hF);

    // R2 arming word, lock; R3 count
    bus_wr(A_CTRL, 32'h12345678);
    rd(A_CTRL, d); check("R2 wrong word ignored", d, 0);
    rd(A_CNT, d);  check("R2 count idle", d, 0);
    bus_wr(A_CTRL, ARM);
    rd(A_CTRL, d); check("R2 armed", d, 1);
    rd(A_CNT, d);  check("R3 loaded", d, 60);
    bus_wr(A_CTRL, 32'h0);
    rd(A_CTRL, d); check("R2 no disarm", d, 1);
    repeat (4) @(negedge clk);
    rd(A_CNT, d);  check("R3 decrement", d, 55);

    // R7 keys before arming ignored
    do_reset();
    bus_wr(A_KEY, K0);
    bus_wr(A_CTRL, ARM);
    bus_wr(A_KEY, K1);
    rd(A_STAT, d); check("R7 pre-arm key ignored status", d, 0);
    rd(A_CNT, d);  check("R7 pre-arm key ignored count", d, 59);
    // wrong middle word
    bus_wr(A_KEY, K0); bus_wr(A_KEY, 32'h1234); bus_wr(A_KEY, K1);
    rd(A_STAT, d); check("R7 wrong word resets", d, 0);
    // repeated first word
    bus_wr(A_KEY, K0); bus_wr(A_KEY, K0); bus_wr(A_KEY, K1);
    rd(A_STAT, d); check("R7 double first word", d, 0);
    // lone second word
    bus_wr(A_KEY, K1);
    rd(A_STAT, d); check("R7 lone second word", d, 0);
    rd(A_CNT, d);  check("R7 lone second word count", d, 52);
    check("R7 no reset request", 32'(rst_req), 0);

    // R4/R9 expiry with interrupt reaction
    do_reset();
    bus_wr(A_RX, 32'h0A);
    bus_wr(A_PRE, 1);
    bus_wr(A_CTRL, ARM);
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk);
      if (j == 4) check("R4 no early fault", 32'(nmi_pulse), 0);
    end
    @(negedge clk);
    check("R4 expiry nmi", 32'(nmi_pulse), 1);
    rd(A_CNT, d); check("R4 reload after expiry", d, 4);
    @(negedge clk);
    check("R9 nmi single cycle", 32'(nmi_pulse), 0);
    rd(A_CNT, d); check("R4 counting again", d, 3);
    check("R9 nmi no reset", 32'(rst_req), 0);

    // R9 other reaction code gives sticky reset request; R10 status clear
    do_reset();
    bus_wr(A_RX, 32'h03);
    bus_wr(A_PRE, 2);
    bus_wr(A_CTRL, ARM);
    repeat (9) @(negedge clk);
    check("R9 reset request", 32'(rst_req), 1);
    check("R9 no nmi", 32'(nmi_pulse), 0);
    rd(A_STAT, d); check("R10 status set", d, 2);
    bus_wr(A_STAT, 0);
    rd(A_STAT, d); check("R10 write zero keeps", d, 2);
    bus_wr(A_STAT, 2);
    rd(A_STAT, d); check("R10 write one clears", d, 0);
    repeat (5) @(negedge clk);
    check("R9 reset request held", 32'(rst_req), 1);

    // R11 reload value and reaction take effect at next reload
    do_reset();
    bus_wr(A_PRE, 2);
    bus_wr(A_CTRL, ARM);
    bus_wr(A_PRE, 3);
    bus_wr(A_RX, 32'h0A);
    rd(A_CNT, d); check("R11 old reload still running", d, 6);
    repeat (7) @(negedge clk);
    check("R11 old reaction used", 32'(rst_req), 1);
    check("R11 old reaction no nmi", 32'(nmi_pulse), 0);
    rd(A_CNT, d); check("R11 new reload applied", d, 12);
    repeat (13) @(negedge clk);
    check("R11 new reaction used", 32'(nmi_pulse), 1);

    // R11 reload and window frozen while pending
    do_reset();
    bus_wr(A_RX, 32'h0A);
    bus_wr(A_PRE, 3);
    bus_wr(A_CTRL, ARM);
    repeat (5) @(negedge clk);
    bus_wr(A_KEY, K0);
    bus_wr(A_PRE, 1);
    bus_wr(A_WIN, 32'h30);
    bus_wr(A_KEY, K1);
    check("R11 frozen window kept open", 32'(nmi_pulse), 0);
    rd(A_CNT, d); check("R11 frozen reload", d, 12);
    rd(A_PRE, d); check("R11 reload write ignored", d, 3);
    rd(A_WIN, d); check("R11 window write ignored", d, 32'h50);

    // R5/R6/R8 sweep: service instant over every count, three windows
    for (int w = 0; w < 3; w++) begin
      for (int p = 1; p <= 3; p++) begin
        r = p << SH;
        for (int dd = 2; dd <= r + 1; dd++) begin
          logic [7:0] wc;
          int k, thr, v;
          logic bad;
          wc  = (w == 0) ? 8'h50 : (w == 1) ? 8'h40 : 8'h30;
          k   = w + 1;
          thr = r >> k;
          v   = r - dd + 1;
          bad = !(v < thr);
          do_reset();
          bus_wr(A_RX, 32'h0A);
          bus_wr(A_WIN, 32'(wc));
          bus_wr(A_PRE, 32'(p));
          bus_wr(A_CTRL, ARM);
          repeat (dd - 2) @(negedge clk);
          bus_wr(A_KEY, K0);
          bus_wr(A_KEY, K1);
          if (bad) check("R6 R8 closed window fault", 32'(nmi_pulse), 1);
          else     check("R5 R8 open window accepted", 32'(nmi_pulse), 0);
          rd(A_STAT, d); check("R10 status after service", d, bad ? 2 : 0);
          rd(A_CNT, d);  check("R5 reload after service", d, 32'(r));
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule